// File: doc/BRIEF.md
# Serial Flash Boot Address-Width Probe

This block is an SPI master used at boot time. It reads a single serial flash or EEPROM whose address length is not known beforehand. When enabled, it pulls its one chip-select line low and shifts out a read command. It then keeps sending address bytes of value zero, one per transfer, until the device starts returning real data.

The data line from the device is pulled up, so a received byte of 0xFF means the device is still taking in address bits. The first byte that is not 0xFF is taken as the first data byte from address zero. The number of zero bytes sent before that byte gives the device's address width: 1, 2, 3 or 4 bytes, which is 8, 16, 24 or 32 address bits. From then on the block clocks in bytes without stopping and presents each one on a simple byte output with a one-cycle valid strobe. It keeps doing so until the enable is withdrawn.

If the device never answers, the block releases the chip select and raises an error flag.

Top module: `flash_addr_probe`

## Requirements
- R1: While `rstN` is low and directly after reset, `spiCsN` is 1, `spiSclk` is 0, and `dataValid`, `detected` and `bootError` are 0.
- R2: SPI mode 0 is used. `spiSclk` stays low whenever `spiCsN` is high. The block samples `spiMiso` on the rising edge of `spiSclk` and changes `spiMosi` after the falling edge.
- R3: Each `spiSclk` high phase and each low phase inside a byte lasts `DIV_VALUE` system clocks. The default `DIV_VALUE` is 0x85, which gives 133 clocks per phase.
- R4: When `bootEn` is high in the idle state, `spiCsN` falls. The first byte shifted out on `spiMosi`, MSB first, is the read command 0x03.
- R5: Every byte sent after the command is 0x00. This holds during both probing and streaming.
- R6: Call the byte received during the j-th zero byte its j-th response. The first response with j ≥ 2 that is not 0xFF sets `detected` = 1 and `addrBytes` = j−1, a value from 1 to 4.
- R7: The first response is ignored even when it is not 0xFF. A device that returns data straight after the command is therefore reported with `addrBytes` = 1, and its second byte is the first one output.
- R8: The detecting byte is output as the first data byte. Every later byte is output as well, each one with a single-cycle `dataValid` pulse and with `dataByte` holding the received value.
- R9: If the fifth response (j = 5) is still 0xFF, `spiCsN` goes high and `bootError` rises. No `dataValid` pulse is produced. `bootError` stays high as long as `bootEn` stays high.
- R10: Driving `bootEn` low in any active state cancels the transfer in progress. On the next clock edge `spiCsN` goes high and `spiSclk` goes low, and `bootError` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bootEn | input | 1 | Level enable: start a probe from idle, cancel when low |
| spiSclk | output | 1 | SPI serial clock, idles low |
| spiCsN | output | 1 | Active-low select for the single device |
| spiMosi | output | 1 | Serial data to the device |
| spiMiso | input | 1 | Serial data from the device (pulled up externally) |
| dataValid | output | 1 | One-cycle strobe for each received data byte |
| dataByte | output | 8 | Received data byte |
| detected | output | 1 | Address width has been found |
| addrBytes | output | 3 | Detected address width in bytes (1 to 4) |
| bootError | output | 1 | No valid response after four address bytes |

## Verification
The hardest situations to reach from the ports are the two edges of the probe window.

The first is a device that drives data during the very first zero byte, which the block must ignore. The second is a device that stays silent through the fifth response, which must end in the error state rather than produce a false detection.

The bench uses a behavioural flash model whose address length can be set anywhere from 0 to 5 bytes. A length of 0 makes the model answer during the first response. A length of 5 keeps the model silent through the fifth response. The same model is used for every width, so the 0xFF-to-data boundary falls at each possible probe byte in turn.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  // Strobes from the probe controller to the shift datapath
  typedef struct packed {
    logic load;   // start a byte transfer
    logic isCmd;  // byte to send is the read command (otherwise zero)
    logic abort;  // drop the transfer in flight
  } xfer_ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_PROBE,
    ST_STREAM,
    ST_FAIL
  } probe_state_t;

endpackage

// File: rtl/probe_spi_datapath.sv
module probe_spi_datapath
  import flash_probe_pkg::*;
#(
  parameter int DIV_VALUE = 133,
  parameter logic [7:0] CMD_BYTE = 8'h03
) (
  input  logic       clk,
  input  logic       rstN,
  input  xfer_ctl_t  ctl,
  input  logic       spiMiso,
  output logic       spiSclk,
  output logic       spiMosi,
  output logic       busy,
  output logic       byteDone,
  output logic [7:0] rxByte
);

  localparam int CNT_W = (DIV_VALUE > 1) ? $clog2(DIV_VALUE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_VALUE - 1);

  logic [CNT_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic             sclkQ;
  logic             tick;

  assign tick     = busy && (divCnt == CNT_LAST);
  assign byteDone = tick && sclkQ && (bitCnt == 3'd7);
  assign spiSclk  = sclkQ;
  assign spiMosi  = txSh[7];
  assign rxByte   = rxSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sclkQ  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      txSh   <= '0;
      rxSh   <= '0;
    end else if (ctl.abort) begin
      busy   <= 1'b0;
      sclkQ  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      txSh   <= '0;
    end else if (ctl.load) begin
      busy   <= 1'b1;
      sclkQ  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      txSh   <= ctl.isCmd ? CMD_BYTE : 8'h00;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        if (!sclkQ) begin
          sclkQ <= 1'b1;                     // rising edge: sample
          rxSh  <= {rxSh[6:0], spiMiso};
        end else begin
          sclkQ <= 1'b0;                     // falling edge: shift
          if (bitCnt == 3'd7) begin
            busy <= 1'b0;
          end else begin
            bitCnt <= bitCnt + 3'd1;
            txSh   <= {txSh[6:0], 1'b0};
          end
        end
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end
    end
  end

  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> !busy); // R5
  AST_SCLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !spiSclk); // R2
  AST_SCLK_PACED: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.abort && busy && divCnt != CNT_LAST) |=> $stable(spiSclk)); // R3

endmodule

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import flash_probe_pkg::*;
#(
  parameter int MAX_ADDR_BYTES = 4,
  localparam int AB_W = $clog2(MAX_ADDR_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bootEn,
  input  logic            byteDone,
  input  logic [7:0]      rxByte,
  output xfer_ctl_t       ctl,
  output logic            spiCsN,
  output logic            dataValid,
  output logic [7:0]      dataByte,
  output logic            detected,
  output logic [AB_W-1:0] addrBytes,
  output logic            bootError
);

  localparam int PC_W = $clog2(MAX_ADDR_BYTES + 2);
  localparam logic [PC_W-1:0] PC_MAX = PC_W'(MAX_ADDR_BYTES);

  probe_state_t    state;
  logic [PC_W-1:0] probeCnt;   // zero bytes completed before the current one
  logic            loadQ;
  logic            cmdQ;
  logic            abortNow;

  assign abortNow = !bootEn && (state != ST_IDLE);

  always_comb begin
    ctl.load  = loadQ;
    ctl.isCmd = cmdQ;
    ctl.abort = abortNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      spiCsN    <= 1'b1;
      loadQ     <= 1'b0;
      cmdQ      <= 1'b0;
      dataValid <= 1'b0;
      dataByte  <= '0;
      detected  <= 1'b0;
      addrBytes <= '0;
      bootError <= 1'b0;
      probeCnt  <= '0;
    end else begin
      loadQ     <= 1'b0;
      dataValid <= 1'b0;
      if (state == ST_IDLE) begin
        if (bootEn) begin
          spiCsN    <= 1'b0;
          loadQ     <= 1'b1;
          cmdQ      <= 1'b1;
          detected  <= 1'b0;
          addrBytes <= '0;
          bootError <= 1'b0;
          probeCnt  <= '0;
          state     <= ST_CMD;
        end
      end else if (abortNow) begin
        spiCsN    <= 1'b1;
        bootError <= 1'b0;
        state     <= ST_IDLE;
      end else begin
        unique case (state)
          ST_CMD: if (byteDone) begin
            loadQ <= 1'b1;
            cmdQ  <= 1'b0;
            state <= ST_PROBE;
          end
          ST_PROBE: if (byteDone) begin
            if (probeCnt != '0 && rxByte != 8'hFF) begin
              detected  <= 1'b1;
              addrBytes <= AB_W'(probeCnt);
              dataValid <= 1'b1;
              dataByte  <= rxByte;
              loadQ     <= 1'b1;
              state     <= ST_STREAM;
            end else if (probeCnt == PC_MAX) begin
              spiCsN    <= 1'b1;
              bootError <= 1'b1;
              state     <= ST_FAIL;
            end else begin
              loadQ    <= 1'b1;
              probeCnt <= probeCnt + PC_W'(1);
            end
          end
          ST_STREAM: if (byteDone) begin
            dataValid <= 1'b1;
            dataByte  <= rxByte;
            loadQ     <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_ERR_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    bootError |-> spiCsN); // R9
  AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    detected |-> (addrBytes >= AB_W'(1) && addrBytes <= AB_W'(MAX_ADDR_BYTES))); // R6
  AST_VALID_NEEDS_DET: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> detected); // R8
  AST_ABORT_CS: assert property (@(posedge clk) disable iff (!rstN)
    abortNow |=> (spiCsN && !bootError)); // R10

endmodule

// File: rtl/flash_addr_probe.sv
module flash_addr_probe
  import flash_probe_pkg::*;
#(
  parameter int DIV_VALUE = 8'h85,
  parameter logic [7:0] CMD_BYTE = 8'h03,
  parameter int MAX_ADDR_BYTES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic bootEn,
  output logic spiSclk,
  output logic spiCsN,
  output logic spiMosi,
  input  logic spiMiso,
  output logic dataValid,
  output logic [7:0] dataByte,
  output logic detected,
  output logic [$clog2(MAX_ADDR_BYTES + 1)-1:0] addrBytes,
  output logic bootError
);

  xfer_ctl_t  ctl;
  logic       busy;
  logic       byteDone;
  logic [7:0] rxByte;

  probe_ctrl #(.MAX_ADDR_BYTES(MAX_ADDR_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .bootEn(bootEn),
    .byteDone(byteDone), .rxByte(rxByte), .ctl(ctl),
    .spiCsN(spiCsN), .dataValid(dataValid), .dataByte(dataByte),
    .detected(detected), .addrBytes(addrBytes), .bootError(bootError)
  );

  probe_spi_datapath #(.DIV_VALUE(DIV_VALUE), .CMD_BYTE(CMD_BYTE)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .spiMiso(spiMiso),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .busy(busy),
    .byteDone(byteDone), .rxByte(rxByte)
  );

  AST_CS_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk); // R2

endmodule

// File: tb/flash_addr_probe_tb_top.sv
module flash_addr_probe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_DIV = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bootEn = 1'b0;
  logic dfltEn = 1'b0;
  logic spiSclk, spiCsN, spiMosi, spiMiso;
  logic dataValid, detected, bootError;
  logic [7:0] dataByte;
  logic [2:0] addrBytes;

  logic dSclk, dCsN, dMosi, dValid, dDet, dErr;
  logic [7:0] dByte;
  logic [2:0] dAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int modelN = 1;
  logic [7:0] modelSeed = 8'h00;
  int bitIdx = 0;
  logic [0:63] mosiLog;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_addr_probe #(.DIV_VALUE(TB_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .bootEn(bootEn), .spiSclk(spiSclk),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .dataValid(dataValid), .dataByte(dataByte), .detected(detected),
    .addrBytes(addrBytes), .bootError(bootError)
  );

  flash_addr_probe dflt_i (
    .clk(clk), .rstN(rstN), .bootEn(dfltEn), .spiSclk(dSclk),
    .spiCsN(dCsN), .spiMosi(dMosi), .spiMiso(1'b1),
    .dataValid(dValid), .dataByte(dByte), .detected(dDet),
    .addrBytes(dAddr), .bootError(dErr)
  );

  // Flash model: pulled-up line until command plus n address bytes have passed
  function automatic logic [7:0] memAt(logic [7:0] seed, int idx);
    return (seed ^ 8'(idx)) & 8'h7F;
  endfunction

  function automatic logic misoBit(int idx, int n, logic [7:0] seed);
    int d;
    logic [7:0] b;
    if (idx < 8 + 8 * n) return 1'b1;
    d = idx - 8 - 8 * n;
    b = memAt(seed, d / 8);
    return b[7 - (d % 8)];
  endfunction

  assign spiMiso = spiCsN ? 1'b1 : misoBit(bitIdx, modelN, modelSeed);

  always @(negedge spiSclk or posedge spiCsN)
    if (spiCsN) bitIdx <= 0;
    else bitIdx <= bitIdx + 1;

  always @(posedge spiSclk)
    if (!spiCsN && bitIdx < 64) mosiLog[bitIdx] <= spiMosi;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // {modelN[15:12], expErr[8], seed[7:0]}
  localparam logic [15:0] VEC [6] = '{
    16'h1021, 16'h204C, 16'h3013, 16'h406E, 16'h0035, 16'h5100
  };

  task automatic runCase(int n, logic [7:0] seed, bit expErr);
    int got = 0;
    int wd = 0;
    int expW = (n == 0) ? 1 : n;
    int first = (n == 0) ? 1 : 0;
    int total;
    bit mosiOk = 1'b1;
    modelN = n;
    modelSeed = seed;
    @(negedge clk) bootEn = 1'b1;
    while (got < 3 && !bootError && wd < 5000) begin
      @(negedge clk);
      wd++;
      if (dataValid) begin
        if (got == 0) begin
          check(detected == 1'b1, "R6", "detected", int'(detected), 1);
          check(int'(addrBytes) == expW, (n == 0) ? "R7" : "R6", "addrBytes", int'(addrBytes), expW);
        end
        check(dataByte == memAt(seed, first + got), "R8", "dataByte",
              int'(dataByte), int'(memAt(seed, first + got)));
        got++;
      end
    end
    check(mosiLog[0:7] == 8'h03, "R4", "command", int'(mosiLog[0:7]), 3);
    total = expErr ? 6 : (1 + (expW + 1) + 2);
    for (int i = 8; i < 8 * total && i < 64; i++) if (mosiLog[i]) mosiOk = 1'b0;
    check(mosiOk, "R5", "zero address bytes", int'(mosiOk), 1);
    if (expErr) begin
      check(bootError && spiCsN && got == 0, "R9", "error/cs/valid",
            int'({bootError, spiCsN}), 3);
      repeat (10) @(negedge clk);
      check(bootError && spiCsN, "R9", "error held", int'(bootError), 1);
      bootEn = 1'b0;
      @(negedge clk);
      check(!bootError, "R10", "error cleared", int'(bootError), 0);
    end else begin
      check(got == 3, "R8", "bytes streamed", got, 3);
      bootEn = 1'b0;   // cancel mid-byte
      @(negedge clk);
      check(spiCsN && !spiSclk, "R10", "abort cs/sclk", int'({spiCsN, spiSclk}), 2);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic measureHigh(bit useDflt, output int n);
    n = 0;
    while (!(useDflt ? dSclk : spiSclk)) @(negedge clk);
    while (useDflt ? dSclk : spiSclk) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int hp;
    repeat (3) @(negedge clk);
    check(spiCsN && !spiSclk, "R1", "reset cs/sclk", int'({spiCsN, spiSclk}), 2);
    check(!dataValid && !detected && !bootError, "R1", "reset flags",
          int'({dataValid, detected, bootError}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(spiCsN && !detected && !bootError, "R1", "after reset",
          int'({spiCsN, detected, bootError}), 4);

    // Clock phase length, bench divider
    modelN = 1;
    bootEn = 1'b1;
    measureHigh(1'b0, hp);
    check(hp == TB_DIV, "R3", "sclk high phase", hp, TB_DIV);
    check(!spiCsN, "R2", "cs low while clocking", int'(spiCsN), 0);
    bootEn = 1'b0;
    @(negedge clk);
    check(spiCsN && !spiSclk, "R2", "sclk idle with cs high", int'({spiCsN, spiSclk}), 2);
    repeat (3) @(negedge clk);

    // Default divider
    dfltEn = 1'b1;
    measureHigh(1'b1, hp);
    check(hp == 133, "R3", "default sclk high phase", hp, 133);
    dfltEn = 1'b0;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 6; v++)
      runCase(int'(VEC[v][15:12]), VEC[v][7:0], VEC[v][8]);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule